// File: doc/BRIEF.md
# Variable-Page Translation Lookaside Buffer

This block is a fully associative translation buffer with 64 slots. Each slot holds two 64-bit words: a tag and a translation entry. A lookup supplies a 64-bit virtual address, an access kind (load, store or fetch) and a user/privileged flag. Every slot is compared in parallel against the address and the current 13-bit context. Each slot's entry names its own page size, so the width of the address compare differs from slot to slot.

The outcome is registered and shown for one cycle after the request. It is one of four results. A hit gives a physical frame address and a permission set. A protection fault is a slot that matches but forbids the access. A miss means no slot matches. A pass-through is given when translation is disabled. Data-side faults are recorded in a fault status register and a fault address register; a second fault recorded before software clears the status marks an overflow. Software loads slots through a write port. Choosing the victim slot and refilling from page tables are left to the surrounding logic.

A small state machine holds the response. Its states are IDLE (no response), HIT, FAULT, MISS and PASS. From any state, the next cycle's state is chosen by the request sampled at the clock edge:
- no request gives IDLE;
- translation disabled gives PASS;
- no matching slot gives MISS;
- a matching slot that forbids the access gives FAULT;
- otherwise the state is HIT.

Top module: `pgvar_tlb`

## Requirements
- R1: Reset clears every slot's tag and entry to zero, sets no response (`rsp_valid` 0, `rsp_kind` 0), and clears `fault_status` and `fault_addr`. After reset, a lookup in context 0 of an address with any of bits 63:13 set misses, and a lookup of address 0 in context 0 faults because it matches the invalid slot 0.
- R2: Entry bits 62:61 give the page size. The code 0 means 8 KB, 1 means 64 KB, 2 means 512 KB and 3 means 4 MB, so the compare ignores the low 13, 16, 19 or 22 address bits. A slot matches when the masked address equals the tag with its bits 12:0 cleared.
- R3: A slot matches only when tag bits 12:0 equal `ctx`.
- R4: When several slots match, the lowest-numbered slot alone decides the result.
- R5: A matching slot faults in three cases: its valid bit (entry bit 63) is 0; its privileged-only bit (entry bit 2) is 1 and `req_user` is 1; or the access is a store (`req_kind` 01) and the writable bit (entry bit 1) is 0.
- R6: On a hit, `rsp_paddr` bits 40:13 take the entry's bits where the page mask is 1 and the address's bits where it is 0. All other `rsp_paddr` bits are 0.
- R7: `rsp_perm` is {exec, write, read} in bits 2:0. A fetch (`req_kind` 1x) hit gives 100. A load or store hit gives 001, or 011 when the writable bit is set.
- R8: On a load or store fault, a nonzero `fault_status` is first replaced by 2 (overflow). It is then ORed with `req_user`<<3, store<<2 and 1, and `fault_addr` takes `req_addr`.
- R9: Fetch faults, misses, hits and pass-throughs leave `fault_status` and `fault_addr` unchanged.
- R10: A miss gives `rsp_kind` 3 and a fault gives `rsp_kind` 2, both with `rsp_perm` 0 and `rsp_paddr` 0. A hit gives `rsp_kind` 1, and no request gives `rsp_kind` 0 with `rsp_valid` 0.
- R11: With `xlate_en` 0, a request gives `rsp_kind` 4 with `rsp_paddr` equal to `req_addr`. The permission is 100 for a fetch and 011 otherwise.
- R12: A request sampled at an edge gives its response in the following cycle. A slot write at the same edge is seen only by later lookups.
- R13: `fault_status` becomes 0 after a cycle with `fault_clr` high. If a data fault is logged in that same cycle, the status holds only the new fault's bits, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_en | input | 1 | Translation enable; 0 selects pass-through |
| ctx | input | 13 | Current context number |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 64 | Virtual address |
| req_kind | input | 2 | 00 load, 01 store, 1x fetch |
| req_user | input | 1 | 1 for a user-mode access |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 6 | Slot to write |
| wr_tag | input | 64 | Tag word to store |
| wr_tte | input | 64 | Translation entry word to store |
| fault_clr | input | 1 | Clears the fault status |
| rsp_valid | output | 1 | A response is present |
| rsp_kind | output | 3 | 0 none, 1 hit, 2 fault, 3 miss, 4 pass |
| rsp_paddr | output | 64 | Physical address |
| rsp_perm | output | 3 | {exec, write, read} |
| fault_status | output | 4 | {user, store, overflow, fault} |
| fault_addr | output | 64 | Address of the last logged fault |

## Verification
The assertions assume that `req_kind` is stable at each sampling edge, and that the tag word of a loaded slot holds no stray bits between 13 and the page boundary that it is meant to match. The priority checks also assume that overlapping slots are loaded on purpose. The stimulus writes every tag already aligned to its page size and creates overlap only in the two-slot priority case. The bench's reference model keeps its own copy of slot contents and fault registers, and it changes them only after the edge that the design uses.

// File: rtl/pgvar_pkg.sv
package pgvar_pkg;

    localparam int WORD_W   = 64;
    localparam int FSR_W    = 4;
    localparam int ENT_VLD  = 63;
    localparam int ENT_SZH  = 62;
    localparam int ENT_SZL  = 61;
    localparam int ENT_PRIV = 2;
    localparam int ENT_WR   = 1;

    localparam logic [2:0] PERM_R = 3'b001;
    localparam logic [2:0] PERM_W = 3'b010;
    localparam logic [2:0] PERM_X = 3'b100;

    // Response state; the encoding is also the response code
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_HIT   = 3'd1,
        S_FAULT = 3'd2,
        S_MISS  = 3'd3,
        S_PASS  = 3'd4
    } rsp_state_e;

    // Mask that keeps the page-number bits for a size code
    function automatic logic [WORD_W-1:0] page_mask(input logic [1:0] sz);
        logic [5:0] sh;
        sh = 6'd13 + {3'b000, sz, 1'b0} + {4'b0000, sz};
        return ~((64'd1 << sh) - 64'd1);
    endfunction

endpackage

// File: rtl/pgvar_slot.sv
module pgvar_slot
    import pgvar_pkg::*;
#(
    parameter int CTX_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] we_tag,
    input  logic [WORD_W-1:0] we_tte,
    input  logic [WORD_W-1:0] lk_addr,
    input  logic [CTX_W-1:0]  lk_ctx,
    output logic              hit,
    output logic [WORD_W-1:0] tte_q
);
    localparam logic [WORD_W-1:0] CTX_FIELD = (WORD_W'(1) << CTX_W) - WORD_W'(1);

    logic [WORD_W-1:0] tag_q;
    logic [WORD_W-1:0] msk;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
            tte_q <= '0;
        end else if (we) begin
            tag_q <= we_tag;
            tte_q <= we_tte;
        end
    end

    always_comb begin
        msk = page_mask(tte_q[ENT_SZH:ENT_SZL]);
        hit = (tag_q[CTX_W-1:0] == lk_ctx) &&
              ((lk_addr & msk) == (tag_q & ~CTX_FIELD));
    end

endmodule

// File: rtl/pgvar_pick.sv
module pgvar_pick #(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  hits,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  sel
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IW'(i);
        end
        any = |hits;
        sel = any ? (N'(1) << idx) : '0;
    end

    always_comb begin
        AST_PICK_ONEHOT: assert ($onehot0(sel));                      // R4
        AST_PICK_LOWEST: assert ((hits & (sel - N'(1))) == '0 || !any); // R4
        AST_PICK_PRESENT: assert (!any || (sel & hits) != '0);        // R4
    end

endmodule

// File: rtl/pgvar_fault_log.sv
module pgvar_fault_log
    import pgvar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              log_en,
    input  logic              clr,
    input  logic              is_user,
    input  logic              is_store,
    input  logic [WORD_W-1:0] addr,
    output logic [FSR_W-1:0]  fsr,
    output logic [WORD_W-1:0] far
);
    logic [FSR_W-1:0] base;

    always_comb begin
        base = clr ? '0 : fsr;
        if (base != '0) base = 4'b0010;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsr <= '0;
            far <= '0;
        end else if (log_en) begin
            fsr <= base | {is_user, is_store, 1'b0, 1'b1};
            far <= addr;
        end else if (clr) begin
            fsr <= '0;
        end
    end

    AST_FSR_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (log_en && !clr && fsr != '0) |=> fsr[1]);                    // R8
    AST_FAR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        log_en |=> (far == $past(addr)) && fsr[0]);                   // R8
    AST_FSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!log_en && !clr) |=> ($stable(fsr) && $stable(far)));        // R9
    AST_FSR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !log_en) |=> (fsr == '0));                            // R13
    AST_FSR_CLEAR_LOG: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && log_en) |=> !fsr[1]);                                 // R13

endmodule

// File: rtl/pgvar_tlb.sv
module pgvar_tlb
    import pgvar_pkg::*;
#(
    parameter int SLOTS = 64,
    parameter int CTX_W = 13,
    parameter int PA_HI = 40,
    parameter int PA_LO = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlate_en,
    input  logic [CTX_W-1:0]  ctx,
    input  logic              req_valid,
    input  logic [63:0]       req_addr,
    input  logic [1:0]        req_kind,
    input  logic              req_user,
    input  logic              wr_en,
    input  logic [$clog2(SLOTS)-1:0] wr_idx,
    input  logic [63:0]       wr_tag,
    input  logic [63:0]       wr_tte,
    input  logic              fault_clr,
    output logic              rsp_valid,
    output logic [2:0]        rsp_kind,
    output logic [63:0]       rsp_paddr,
    output logic [2:0]        rsp_perm,
    output logic [3:0]        fault_status,
    output logic [63:0]       fault_addr
);
    localparam int IW = $clog2(SLOTS);
    localparam logic [WORD_W-1:0] PA_FIELD =
        ((WORD_W'(1) << (PA_HI + 1)) - WORD_W'(1)) & ~((WORD_W'(1) << PA_LO) - WORD_W'(1));

    logic [SLOTS-1:0]  hits;
    logic [WORD_W-1:0] tte_all [SLOTS];
    logic              any_hit;
    logic [IW-1:0]     pick_idx;
    logic [SLOTS-1:0]  pick_sel;

    // ---------------- slot array ----------------
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        pgvar_slot #(.CTX_W(CTX_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (wr_en && (wr_idx == IW'(g))),
            .we_tag  (wr_tag),
            .we_tte  (wr_tte),
            .lk_addr (req_addr),
            .lk_ctx  (ctx),
            .hit     (hits[g]),
            .tte_q   (tte_all[g])
        );
    end

    pgvar_pick #(.N(SLOTS), .IW(IW)) u_pick (
        .hits (hits),
        .any  (any_hit),
        .idx  (pick_idx),
        .sel  (pick_sel)
    );

    // ---------------- decision ----------------
    logic [WORD_W-1:0] sel_tte;
    logic [WORD_W-1:0] sel_msk;
    logic              is_fetch, is_store, prot_fault, log_en;
    rsp_state_e        state_d, state_q;
    logic [63:0]       paddr_d, paddr_q;
    logic [2:0]        perm_d, perm_q;

    always_comb begin
        sel_tte    = tte_all[pick_idx];
        sel_msk    = page_mask(sel_tte[ENT_SZH:ENT_SZL]);
        is_fetch   = req_kind[1];
        is_store   = (req_kind == 2'b01);
        prot_fault = !sel_tte[ENT_VLD] ||
                     (sel_tte[ENT_PRIV] && req_user) ||
                     (is_store && !sel_tte[ENT_WR]);
        log_en     = req_valid && xlate_en && any_hit && prot_fault && !is_fetch;
    end

    always_comb begin
        state_d = S_IDLE;
        paddr_d = '0;
        perm_d  = '0;
        if (req_valid) begin
            if (!xlate_en) begin
                state_d = S_PASS;
                paddr_d = req_addr;
                perm_d  = is_fetch ? PERM_X : (PERM_R | PERM_W);
            end else if (!any_hit) begin
                state_d = S_MISS;
            end else if (prot_fault) begin
                state_d = S_FAULT;
            end else begin
                state_d = S_HIT;
                paddr_d = (sel_tte & sel_msk & PA_FIELD) | (req_addr & ~sel_msk & PA_FIELD);
                perm_d  = is_fetch ? PERM_X
                                   : (PERM_R | (sel_tte[ENT_WR] ? PERM_W : 3'b000));
            end
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0;
            perm_q  <= '0;
        end else begin
            paddr_q <= paddr_d;
            perm_q  <= perm_d;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        rsp_valid = 1'b1;
        rsp_kind  = state_q;
        rsp_paddr = '0;
        rsp_perm  = '0;
        unique case (state_q)
            S_IDLE:  rsp_valid = 1'b0;
            S_HIT:   begin rsp_paddr = paddr_q; rsp_perm = perm_q; end
            S_PASS:  begin rsp_paddr = paddr_q; rsp_perm = perm_q; end
            S_FAULT: ;
            S_MISS:  ;
            default: begin rsp_valid = 1'b0; rsp_kind = S_IDLE; end
        endcase
    end

    pgvar_fault_log u_flog (
        .clk      (clk),
        .rst_n    (rst_n),
        .log_en   (log_en),
        .clr      (fault_clr),
        .is_user  (req_user),
        .is_store (is_store),
        .addr     (req_addr),
        .fsr      (fault_status),
        .far      (fault_addr)
    );

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);                                   // R12
    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);                                     // R12
    AST_PASS_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xlate_en) |=> (rsp_paddr == $past(req_addr))); // R11
    AST_NOPERM_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FAULT || state_q == S_MISS) |-> (rsp_perm == 3'b000 && rsp_paddr == '0)); // R10
    AST_FETCH_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind[1]) |=> (!rsp_valid || rsp_kind == 3'd2 || rsp_kind == 3'd3 || rsp_perm == PERM_X)); // R7
    AST_PA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HIT) |-> ((rsp_paddr & ~PA_FIELD) == '0));      // R6

endmodule

// File: tb/pgvar_tlb_test.sv
module pgvar_tlb_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlate_en = 1'b0;
    logic [12:0] ctx = '0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_tag = '0;
    logic [63:0] wr_tte = '0;
    logic        fault_clr = 1'b0;
    logic        rsp_valid;
    logic [2:0]  rsp_kind;
    logic [63:0] rsp_paddr;
    logic [2:0]  rsp_perm;
    logic [3:0]  fault_status;
    logic [63:0] fault_addr;

    always #5 clk = ~clk;

    pgvar_tlb uut (.*);

    logic [63:0] m_tag [64];
    logic [63:0] m_tte [64];
    logic [3:0]  m_fsr = '0;
    logic [63:0] m_far = '0;
    int errs = 0;
    int checks = 0;
    bit done = 0;

    localparam logic [63:0] FIELD = 64'h0000_01FF_FFFF_E000;

    task automatic chk(string r, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    // One clock: predict, let the edge pass, update model, compare
    task automatic tick(string r);
        logic [2:0]  ek;
        logic [63:0] ep;
        logic [2:0]  eperm;
        logic [63:0] t, msk;
        bit          found, logit, flt;
        int          sel;
        ek = 0; ep = 0; eperm = 0; logit = 0; found = 0; sel = 0; t = 0; msk = 0;
        if (req_valid) begin
            if (!xlate_en) begin
                ek = 4; ep = req_addr; eperm = req_kind[1] ? 3'b100 : 3'b011;
            end else begin
                for (int i = 0; i < 64; i++) begin
                    msk = ~((64'd1 << (13 + 3 * int'(m_tte[i][62:61]))) - 64'd1);
                    if (!found && m_tag[i][12:0] == ctx &&
                        (req_addr & msk) == (m_tag[i] & ~64'h1FFF)) begin
                        found = 1; sel = i;
                    end
                end
                if (!found) ek = 3;
                else begin
                    t   = m_tte[sel];
                    msk = ~((64'd1 << (13 + 3 * int'(t[62:61]))) - 64'd1);
                    flt = !t[63] || (t[2] && req_user) || (req_kind == 2'b01 && !t[1]);
                    if (flt) begin
                        ek = 2; logit = !req_kind[1];
                    end else begin
                        ek = 1;
                        ep = (t & msk & FIELD) | (req_addr & ~msk & FIELD);
                        eperm = req_kind[1] ? 3'b100 : (t[1] ? 3'b011 : 3'b001);
                    end
                end
            end
        end
        @(posedge clk);
        if (fault_clr) m_fsr = 0;
        if (logit) begin
            m_fsr = ((m_fsr != 0) ? 4'd2 : 4'd0) | {req_user, req_kind == 2'b01, 1'b0, 1'b1};
            m_far = req_addr;
        end
        if (wr_en) begin
            m_tag[wr_idx] = wr_tag;
            m_tte[wr_idx] = wr_tte;
        end
        @(negedge clk);
        chk(r, "rsp_valid", 64'(rsp_valid), 64'(ek != 0));
        chk(r, "rsp_kind", 64'(rsp_kind), 64'(ek));
        chk(r, "rsp_paddr", rsp_paddr, ep);
        chk(r, "rsp_perm", 64'(rsp_perm), 64'(eperm));
        chk(r, "fault_status", 64'(fault_status), 64'(m_fsr));
        chk(r, "fault_addr", fault_addr, m_far);
    endtask

    task automatic do_req(logic [1:0] k, logic u, logic [63:0] a, string r);
        req_valid = 1; req_kind = k; req_user = u; req_addr = a;
        tick(r);
        req_valid = 0;
    endtask

    task automatic do_wr(int i, logic [63:0] tg, logic [63:0] te, string r);
        wr_en = 1; wr_idx = 6'(i); wr_tag = tg; wr_tte = te;
        tick(r);
        wr_en = 0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin m_tag[i] = 0; m_tte[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        chk("R1", "reset rsp_valid", 64'(rsp_valid), 0);
        chk("R1", "reset fsr", 64'(fault_status), 0);
        chk("R1", "reset far", fault_addr, 0);
        tick("R1_idle");

        // reset contents: zero tags and entries
        xlate_en = 1; ctx = 0;
        do_req(2'b00, 0, 64'h0000_0000_0000_5000, "R1_miss");
        do_req(2'b00, 0, 64'h0000_0000_0000_0123, "R1_slot0_invalid_fault");
        fault_clr = 1; tick("R13_clear"); fault_clr = 0;

        // pass-through
        xlate_en = 0;
        do_req(2'b00, 1, 64'hDEAD_BEEF_0123_4567, "R11_load");
        do_req(2'b10, 0, 64'h0000_0000_8000_0004, "R11_fetch");
        do_req(2'b01, 0, 64'h1111_2222_3333_4444, "R11_store");
        xlate_en = 1; ctx = 7;

        // write and lookup at the same edge: old contents seen
        wr_en = 1; wr_idx = 5; wr_tag = 64'h0000_1234_5678_A007; wr_tte = 64'h8000_0123_4567_8002;
        do_req(2'b00, 0, 64'h0000_1234_5678_B5A4, "R12_same_edge");
        wr_en = 0;
        do_req(2'b00, 0, 64'h0000_1234_5678_B5A4, "R2_8k_hit");
        do_req(2'b01, 1, 64'h0000_1234_5678_A000, "R7_store_rw");
        do_req(2'b00, 0, 64'h0000_1234_5678_C000, "R2_8k_outside");

        do_wr(10, 64'hFFFF_8000_0040_0007, 64'hE000_00AB_CC00_0004, "R2_load4m");
        do_wr(11, 64'h0000_0000_1234_0009, 64'hA000_0000_5555_0002, "R2_load64k");
        do_wr(12, 64'h0000_0000_0A08_0007, 64'hC000_0001_2340_0000, "R2_load512k");
        do_req(2'b00, 0, 64'hFFFF_8000_007F_FFF8, "R6_4m_hit");
        do_req(2'b00, 0, 64'hFFFF_8000_0080_0000, "R2_4m_outside");
        do_req(2'b00, 0, 64'h0000_0000_0A0F_FFFF, "R6_512k_hit");
        do_req(2'b00, 0, 64'h0000_0000_0A10_0000, "R2_512k_outside");

        // context
        ctx = 9;
        do_req(2'b00, 0, 64'h0000_1234_5678_B5A4, "R3_ctx_mismatch");
        do_req(2'b00, 0, 64'h0000_0000_1234_FFFC, "R3_64k_hit");
        ctx = 7;
        do_req(2'b00, 0, 64'h0000_0000_1234_FFFC, "R3_64k_wrong_ctx");

        // priority between two matching slots
        do_wr(20, 64'h5000_0000_0000_2007, 64'h8000_0000_0009_0002, "R4_load20");
        do_wr(3,  64'h5000_0000_0000_2007, 64'h8000_0000_0003_0000, "R4_load3");
        do_req(2'b00, 0, 64'h5000_0000_0000_2ABC, "R4_lowest_load");
        do_req(2'b01, 0, 64'h5000_0000_0000_2ABC, "R4_R5_store_ro");

        // fault logging with overflow
        do_req(2'b00, 1, 64'hFFFF_8000_0041_0000, "R5_R8_user_priv_overflow");
        fault_clr = 1; tick("R13_clear2"); fault_clr = 0;
        do_req(2'b00, 1, 64'hFFFF_8000_0042_0000, "R8_user_fault");
        do_req(2'b01, 0, 64'h0000_0000_0A08_1000, "R8_store_ro_overflow");

        // no logging cases
        do_req(2'b10, 1, 64'hFFFF_8000_0043_0000, "R9_fetch_fault");
        do_req(2'b10, 0, 64'hFFFF_8000_0043_0000, "R7_fetch_hit");
        do_req(2'b00, 0, 64'h0000_0000_0000_9000, "R9_miss");
        do_req(2'b11, 0, 64'h0000_1234_5678_B000, "R7_fetch_code3");

        // invalid matching slot, clear with fault in same cycle
        do_wr(30, 64'h0000_0000_7000_0007, 64'h0000_0000_0000_0002, "R5_load_invalid");
        fault_clr = 1;
        do_req(2'b00, 0, 64'h0000_0000_7000_1FFF, "R5_R13_invalid_clr");
        fault_clr = 0;
        do_req(2'b01, 1, 64'h0000_0000_7000_0000, "R10_fault_again");
        tick("R10_idle");

        done = 1;
        finish_run();
    end

endmodule